// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 interrupt inputs and presents one active-low request line to a processor. Each input has its own control byte that sets what counts as a request: a low level, a high level, a falling edge or a rising edge. The same byte holds a 3-bit priority. A per-source enable bit gates each request. The enable bits are changed only through write-1 unmask and mask command registers. Software can also force a source pending, or clear a latched request, with two further write-1 commands.

The processor reads the vector register to claim an interrupt. The read returns the byte offset of the winning source (its index times four) and releases the request line. The controller then holds off every further request until software writes the end-of-service register. Status views let software inspect the requests: raw requests, unmasked requests, the one source in service, its index, the enable bits and the state of the request line. Priority 7 ranks highest. When several sources share the top priority, the lowest index wins.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset the request line `irq_n` is high, the enable register (0x114) reads 0, every control byte reads 0x00, and active status (0x104) and output status (0x118) read 0.
- R2: The control byte of source n sits at byte offset 4*n. Bits [7:6] are the trigger type (0 low level, 1 high level, 2 falling edge, 3 rising edge) and bits [2:0] the priority. Bits [5:3] read back as 0.
- R3: For a level-type source, raw status (0x100) bit n equals the input for high level and the inverted input for low level, as long as nothing is latched for that source.
- R4: For an edge-type source, the selected edge sets raw bit n, and the bit stays set after the input returns. Writing 1s to the clear command (0x12C) clears the latched bits selected by those 1s.
- R5: Writing 1s to 0x120 sets the matching enable bits, and writing 1s to 0x124 clears them. Zero bits leave their sources unchanged. The enable register reads at 0x114 (1 = unmasked), and status (0x108) reads raw AND enable.
- R6: While no source is in service, `irq_n` goes low the cycle after an unmasked source becomes pending.
- R7: A read of 0x10C returns 4 times the winning source index. The winner is the pending unmasked source with the highest priority (7 highest), and on a tie the lowest index.
- R8: A vector read while `irq_n` is low claims the winner. `irq_n` is high on the next cycle, active status holds a single 1 at the winner's bit, 0x110 reads the winner's index, and the winner's latched request is cleared.
- R9: While a source is in service, `irq_n` stays high. Any write to 0x130 ends service, clears active status, and lets `irq_n` fall on the next cycle if a request is pending.
- R10: Writing 1s to the set command (0x128) latches those sources pending whatever their input level. The latch is cleared by a vector read that claims the source or by the clear command.
- R11: Output status (0x118) bit 0 reads 1 exactly when the request line is asserted.
- R12: A vector read while `irq_n` is high claims nothing: active status stays 0 and later requests are still presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Interrupt source inputs |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
On every cycle the assertions check the service handshake. The request line stays high during service, and a claim releases it on the next cycle. Service ends only on an end-of-service write. A low request line always follows a pending request, active status never holds more than one bit, and a mask-all command empties the enable register. Other behaviour only the bench's scenarios can show. These are the winner selection over swept priority and pending patterns, the trigger decoding for each type, edge latching and clearing, the register read-back values, and the absence of side effects when a vector read is not a claim.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  localparam int OFS_RAW    = 'h100;
  localparam int OFS_ACTIVE = 'h104;
  localparam int OFS_STATUS = 'h108;
  localparam int OFS_VECTOR = 'h10C;
  localparam int OFS_SRCNUM = 'h110;
  localparam int OFS_ENABLE = 'h114;
  localparam int OFS_OUTSTS = 'h118;
  localparam int OFS_UNMASK = 'h120;
  localparam int OFS_MASK   = 'h124;
  localparam int OFS_SET    = 'h128;
  localparam int OFS_CLEAR  = 'h12C;
  localparam int OFS_EOS    = 'h130;

  // Byte offset returned on a vector read: index scaled by the register stride.
  function automatic logic [31:0] vec_offset(input logic [31:0] idx);
    return idx << 2;
  endfunction

  // Does an input pair (now, previous) raise a request for a given trigger type?
  function automatic logic level_req(input trig_e t, input logic now);
    case (t)
      TRIG_HIGH: return now;
      TRIG_LOW:  return ~now;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic edge_req(input trig_e t, input logic now, input logic prev);
    case (t)
      TRIG_RISE: return now & ~prev;
      TRIG_FALL: return ~now & prev;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vpic_src_bank.sv
module vpic_src_bank
  import vpic_pkg::*;
#(
  parameter int N  = 32,
  parameter int PW = 3,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    src_in,
  input  logic            ctrl_we,
  input  logic [IW-1:0]   ctrl_idx,
  input  logic [7:0]      ctrl_wdata,
  input  logic [N-1:0]    set_cmd,
  input  logic [N-1:0]    clr_cmd,
  input  logic [N-1:0]    take_clr,
  output logic [N-1:0]    raw,
  output logic [N*PW-1:0] prio_flat,
  output logic [N*8-1:0]  ctrl_flat
);

  for (genvar g = 0; g < N; g++) begin : g_src
    trig_e          trig_q;
    logic [PW-1:0]  prio_q;
    logic           src_q;
    logic           lat_q;
    logic           edge_hit;

    assign edge_hit = edge_req(trig_q, src_in[g], src_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_q <= TRIG_LOW;
        prio_q <= '0;
        src_q  <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        src_q <= src_in[g];
        if (ctrl_we && ctrl_idx == IW'(g)) begin
          trig_q <= trig_e'(ctrl_wdata[7:6]);
          prio_q <= ctrl_wdata[PW-1:0];
        end
        if (edge_hit || set_cmd[g])
          lat_q <= 1'b1;
        else if (clr_cmd[g] || take_clr[g])
          lat_q <= 1'b0;
      end
    end

    assign raw[g]                  = level_req(trig_q, src_in[g]) | lat_q;
    assign prio_flat[g*PW +: PW]   = prio_q;
    assign ctrl_flat[g*8 +: 8]     = {trig_q, {(6-PW){1'b0}}, prio_q};
  end

endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int N  = 32,
  parameter int PW = 3,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    pend,
  input  logic [N*PW-1:0] prio_flat,
  output logic [IW-1:0]   win_idx,
  output logic            pend_any
);

  // Scan from the top index down; ">=" lets a lower index take over a tie.
  function automatic logic [IW:0] pick(input logic [N-1:0] p, input logic [N*PW-1:0] pf);
    logic          found;
    logic [PW-1:0] best;
    logic [IW-1:0] idx;
    found = 1'b0;
    best  = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (p[i] && (!found || pf[i*PW +: PW] >= best)) begin
        found = 1'b1;
        best  = pf[i*PW +: PW];
        idx   = IW'(i);
      end
    end
    return {found, idx};
  endfunction

  assign {pend_any, win_idx} = pick(pend, prio_flat);

endmodule

// File: rtl/vpic_service.sv
module vpic_service #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_any,
  input  logic          vec_rd,
  input  logic          eos_wr,
  input  logic [IW-1:0] win_idx,
  output logic          irq_q,
  output logic          in_service,
  output logic          vec_take,
  output logic [IW-1:0] srv_idx
);

  assign vec_take = vec_rd & irq_q & pend_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q      <= 1'b0;
      in_service <= 1'b0;
      srv_idx    <= '0;
    end else if (vec_take) begin
      irq_q      <= 1'b0;
      in_service <= 1'b1;
      srv_idx    <= win_idx;
    end else if (eos_wr && in_service) begin
      in_service <= 1'b0;
      irq_q      <= pend_any;
    end else begin
      irq_q      <= ~in_service & pend_any;
    end
  end

endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int N  = 32,
  parameter int PW = 3,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_in,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_n
);

  localparam int IW = $clog2(N);
  localparam logic [AW-1:0] A_RAW    = AW'(OFS_RAW);
  localparam logic [AW-1:0] A_ACTIVE = AW'(OFS_ACTIVE);
  localparam logic [AW-1:0] A_STATUS = AW'(OFS_STATUS);
  localparam logic [AW-1:0] A_VECTOR = AW'(OFS_VECTOR);
  localparam logic [AW-1:0] A_SRCNUM = AW'(OFS_SRCNUM);
  localparam logic [AW-1:0] A_ENABLE = AW'(OFS_ENABLE);
  localparam logic [AW-1:0] A_OUTSTS = AW'(OFS_OUTSTS);
  localparam logic [AW-1:0] A_UNMASK = AW'(OFS_UNMASK);
  localparam logic [AW-1:0] A_MASK   = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_SET    = AW'(OFS_SET);
  localparam logic [AW-1:0] A_CLEAR  = AW'(OFS_CLEAR);
  localparam logic [AW-1:0] A_EOS    = AW'(OFS_EOS);

  // Named internal events, also observed by the bound checker.
  logic            ctrl_hit, ctrl_we, vec_rd, eos_wr, vec_take, pend_any;
  logic            irq_q, in_service;
  logic [IW-1:0]   ctrl_idx, win_idx, srv_idx;
  logic [N-1:0]    en_q, raw, pend, set_cmd, clr_cmd, take_clr, act_vec;
  logic [N*PW-1:0] prio_flat;
  logic [N*8-1:0]  ctrl_flat;

  assign ctrl_hit = (bus_addr[1:0] == 2'b00) && ({2'b00, bus_addr[AW-1:2]} < AW'(N));
  assign ctrl_idx = bus_addr[IW+1:2];
  assign ctrl_we  = bus_wr && ctrl_hit;
  assign vec_rd   = bus_rd && (bus_addr == A_VECTOR);
  assign eos_wr   = bus_wr && (bus_addr == A_EOS);
  assign set_cmd  = (bus_wr && bus_addr == A_SET)   ? bus_wdata[N-1:0] : '0;
  assign clr_cmd  = (bus_wr && bus_addr == A_CLEAR) ? bus_wdata[N-1:0] : '0;
  assign take_clr = vec_take ? (N'(1) << win_idx) : '0;
  assign pend     = raw & en_q;
  assign act_vec  = in_service ? (N'(1) << srv_idx) : '0;
  assign irq_n    = ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= '0;
    else if (bus_wr && bus_addr == A_UNMASK)
      en_q <= en_q | bus_wdata[N-1:0];
    else if (bus_wr && bus_addr == A_MASK)
      en_q <= en_q & ~bus_wdata[N-1:0];
  end

  vpic_src_bank #(.N(N), .PW(PW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_in     (src_in),
    .ctrl_we    (ctrl_we),
    .ctrl_idx   (ctrl_idx),
    .ctrl_wdata (bus_wdata[7:0]),
    .set_cmd    (set_cmd),
    .clr_cmd    (clr_cmd),
    .take_clr   (take_clr),
    .raw        (raw),
    .prio_flat  (prio_flat),
    .ctrl_flat  (ctrl_flat)
  );

  vpic_arbiter #(.N(N), .PW(PW)) u_arb (
    .pend      (pend),
    .prio_flat (prio_flat),
    .win_idx   (win_idx),
    .pend_any  (pend_any)
  );

  vpic_service #(.N(N)) u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_any   (pend_any),
    .vec_rd     (vec_rd),
    .eos_wr     (eos_wr),
    .win_idx    (win_idx),
    .irq_q      (irq_q),
    .in_service (in_service),
    .vec_take   (vec_take),
    .srv_idx    (srv_idx)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RAW:    bus_rdata = DW'(raw);
      A_ACTIVE: bus_rdata = DW'(act_vec);
      A_STATUS: bus_rdata = DW'(pend);
      A_VECTOR: bus_rdata = DW'(vec_offset(32'(win_idx)));
      A_SRCNUM: bus_rdata = DW'(srv_idx);
      A_ENABLE: bus_rdata = DW'(en_q);
      A_OUTSTS: bus_rdata = DW'(irq_q);
      default:  if (ctrl_hit) bus_rdata = DW'(ctrl_flat[ctrl_idx*8 +: 8]);
    endcase
  end

endmodule

// File: rtl/vpic_checker.sv
module vpic_checker
  import vpic_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_n,
  input logic          in_service,
  input logic          vec_take,
  input logic          eos_wr,
  input logic          pend_any,
  input logic [N-1:0]  act_vec,
  input logic [N-1:0]  en_q,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata
);

  assert_quiet_in_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_service |-> irq_n);

  assert_claim_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |=> (irq_n && in_service));

  assert_leave_on_eos_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_service) |-> $past(eos_wr));

  assert_irq_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(pend_any));

  assert_single_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_vec) && (in_service == (act_vec != '0)));

  assert_mask_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(OFS_MASK) && bus_wdata[N-1:0] == {N{1'b1}}) |=> (en_q == '0));

endmodule

bind vpic_ctrl vpic_checker #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_n      (irq_n),
  .in_service (in_service),
  .vec_take   (vec_take),
  .eos_wr     (eos_wr),
  .pend_any   (pend_any),
  .act_vec    (act_vec),
  .en_q       (en_q),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata)
);

// File: tb/vpic_ctrl_test.sv
`timescale 1ns/1ps
module vpic_ctrl_test;

  localparam logic [11:0] RAW = 12'h100, ACT = 12'h104, STS = 12'h108, VEC = 12'h10C,
                          NUM = 12'h110, ENR = 12'h114, OUT = 12'h118, UNM = 12'h120,
                          MSK = 12'h124, SETC = 12'h128, CLR = 12'h12C, EOS = 12'h130;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         irq_n;
  int          checks = 0, fails = 0;
  int          prio_tab[32];

  always #2 clk = ~clk;

  vpic_ctrl uut (.clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
                 .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Winner restated as a score: priority dominates, then smaller index.
  function automatic int winner(input logic [31:0] p);
    int bs = -1, bi = 0;
    for (int i = 0; i < 32; i++) begin
      if (p[i] && (prio_tab[i] * 64 + (63 - i)) > bs) begin
        bs = prio_tab[i] * 64 + (63 - i);
        bi = i;
      end
    end
    return bi;
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d, s, e, p;
    int w;
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    chk("R1 irq_n", 32'(irq_n), 32'd1);
    rdchk("R1 enable", ENR, 0);
    rdchk("R1 active", ACT, 0);
    rdchk("R1 outsts", OUT, 0);
    for (int n = 0; n < 32; n++) rdchk("R1 ctrl", 12'(n * 4), 0);

    // R2 control byte placement, stray bits dropped
    for (int n = 0; n < 32; n++) wr(12'(n * 4), 32'((n * 37) & 8'hFF) | 32'h38);
    for (int n = 0; n < 32; n++) rdchk("R2 ctrl", 12'(n * 4), 32'((n * 37) & 8'hC7));

    // R3 level decoding
    for (int n = 0; n < 32; n++) wr(12'(n * 4), 32'h40);
    wr(CLR, '1);
    src_in = 32'hA5C3_0F96; settle(1);
    rdchk("R3 high level", RAW, 32'hA5C3_0F96);
    src_in = 32'h1234_8001; settle(1);
    rdchk("R3 high level", RAW, 32'h1234_8001);
    for (int n = 0; n < 32; n++) wr(12'(n * 4), 32'h00);
    rdchk("R3 low level", RAW, ~32'h1234_8001);

    // R4 edge latching and clear command
    src_in = '0;
    for (int n = 0; n < 32; n++) wr(12'(n * 4), 32'hC0);
    wr(CLR, '1);
    src_in = 32'hF00D_1234; settle(2);
    src_in = '0; settle(2);
    rdchk("R4 rising latched", RAW, 32'hF00D_1234);
    wr(CLR, 32'h0000_FFFF);
    rdchk("R4 partial clear", RAW, 32'hF00D_0000);
    for (int n = 0; n < 32; n++) wr(12'(n * 4), 32'h80);
    src_in = '1; settle(2);
    wr(CLR, '1);
    rdchk("R4 no latch on rise in falling mode", RAW, 0);
    src_in = ~32'h0C0C_8421; settle(2);
    src_in = '1; settle(2);
    rdchk("R4 falling latched", RAW, 32'h0C0C_8421);
    wr(CLR, '1);

    // R5 enable commands and status
    for (int n = 0; n < 32; n++) wr(12'(n * 4), 32'h40);
    src_in = 32'h00FF_00FF; settle(1);
    wr(UNM, 32'h0000_0F0F);
    rdchk("R5 unmask", ENR, 32'h0000_0F0F);
    wr(UNM, 32'h00F0_00F0);
    rdchk("R5 unmask accumulates", ENR, 32'h00F0_0FFF);
    wr(MSK, 32'h0000_0303);
    rdchk("R5 mask", ENR, 32'h00F0_0CFC);
    wr(MSK, 0); wr(UNM, 0);
    rdchk("R5 zero bits no effect", ENR, 32'h00F0_0CFC);
    rdchk("R5 status", STS, 32'h00F0_00FC);
    wr(MSK, '1);
    rdchk("R5 mask all", ENR, 0);
    settle(2);
    chk("R6 idle when nothing unmasked", 32'(irq_n), 1);

    // R6-R9, R11 priority sweep
    for (int t = 0; t < 8; t++) begin
      for (int n = 0; n < 32; n++) begin
        prio_tab[n] = (n * 5 + t * 3 + n / 4 + t * n) % 8;
        wr(12'(n * 4), 32'h40 | 32'(prio_tab[n]));
      end
      s = 32'h9E37_79B9 * 32'(t + 1);
      e = ~(32'h0F0F_1234 << t);
      if ((s & e) == 0) e = '1;
      p = s & e;
      w = winner(p);
      src_in = s;
      wr(UNM, e);
      settle(2);
      chk("R6 irq asserted", 32'(irq_n), 0);
      rdchk("R11 outsts high", OUT, 1);
      rdchk("R7 vector", VEC, 32'(w * 4));
      chk("R8 irq released", 32'(irq_n), 1);
      rdchk("R8 active", ACT, 32'(1) << w);
      rdchk("R8 srcnum", NUM, 32'(w));
      rdchk("R11 outsts low", OUT, 0);
      settle(4);
      chk("R9 held off", 32'(irq_n), 1);
      wr(EOS, 0);
      rdchk("R9 active cleared", ACT, 0);
      chk("R9 reassert", 32'(irq_n), 0);
      rdchk("R7 vector again", VEC, 32'(w * 4));
      wr(EOS, 32'hDEAD_BEEF);
      wr(MSK, '1);
      settle(2);
      chk("R6 quiet after mask", 32'(irq_n), 1);
    end

    // R7 tie at equal priority
    for (int n = 0; n < 32; n++) begin
      prio_tab[n] = 5;
      wr(12'(n * 4), 32'h45);
    end
    src_in = 32'h0010_0088;
    wr(UNM, '1); settle(2);
    rdchk("R7 tie lowest index", VEC, 32'd12);
    wr(EOS, 0); wr(MSK, 32'h8); settle(2);
    rdchk("R7 tie next", VEC, 32'd28);
    wr(EOS, 0); wr(MSK, '1); settle(2);

    // R8 claim clears edge latch
    src_in = '0;
    for (int n = 0; n < 32; n++) wr(12'(n * 4), 32'h40);
    wr(12'(9 * 4), 32'hC7);
    wr(CLR, '1);
    wr(UNM, 32'h200); settle(2);
    chk("R4 no edge no irq", 32'(irq_n), 1);
    src_in[9] = 1'b1; settle(1);
    src_in[9] = 1'b0; settle(2);
    rdchk("R4 edge held", RAW, 32'h200);
    chk("R6 edge irq", 32'(irq_n), 0);
    rdchk("R7 edge vector", VEC, 32'd36);
    rdchk("R8 latch cleared by claim", RAW, 0);
    wr(EOS, 0); settle(2);
    chk("R9 nothing pending", 32'(irq_n), 1);
    wr(MSK, '1);

    // R12 vector read with no request
    rdchk("R12 vector value", VEC, 0);
    rdchk("R12 no claim", ACT, 0);
    chk("R12 irq idle", 32'(irq_n), 1);

    // R10 set command
    wr(12'(4 * 4), 32'h41);
    wr(SETC, 32'h10);
    wr(UNM, 32'h10); settle(2);
    chk("R12 still presents", 32'(irq_n), 0);
    rdchk("R10 set vector", VEC, 32'd16);
    rdchk("R10 cleared by claim", RAW, 0);
    wr(EOS, 0);
    wr(SETC, 32'h10); settle(2);
    rdchk("R10 set latched", RAW, 32'h10);
    chk("R10 set irq", 32'(irq_n), 0);
    wr(CLR, 32'h10); settle(2);
    rdchk("R10 cleared by command", RAW, 0);
    chk("R10 irq drops", 32'(irq_n), 1);

    summary();
  end

endmodule